// File: doc/BRIEF.md
# Reorder Buffer with Register Rename Table

This block is the in-order bookkeeping heart of a small out-of-order core. Decoded instructions enter a circular queue at the tail in program order. At entry, each source operand is resolved from a rename table that stands in front of the architectural register file. The operand is either taken as a value right away or marked as waiting on the tag of the queue slot that will produce it. A picker chooses one entry whose operands are both present, oldest first counted from the head, and sends it to a single ALU. The ALU here is a stand-in with four operations.

The ALU result is written back into the chosen slot. In the same edge, the slot's tag is broadcast, and every entry waiting on that tag captures the value. Completed entries leave from the head one per cycle and write their result into the architectural register file. A rename mapping is released only when it still points at the retiring slot. An instruction flagged as trapping that reaches the head discards the whole queue and every rename mapping in one cycle.

Top module: `ooo_rob_core`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `ret_valid`, `exec_valid` and `flush_out` are 0, and architectural register r reads back the value r.
- R2: `disp_ready` is 0 exactly when DEPTH instructions are in flight or a flush is happening this cycle; the occupancy never exceeds DEPTH.
- R3: Non-trapping instructions retire one per cycle in dispatch order. `ret_valid` with `ret_dest`/`ret_value` reports the retirement, and the value is in the register file from the next cycle.
- R4: A source reads the register file when the register is not renamed, the producing slot's result when that slot has completed, or the ALU result when the producer executes in the same cycle. Otherwise it waits. Results equal those of a sequential, in-order execution.
- R5: When a slot executes, every entry waiting on that slot's tag captures the value in the same edge, and the executed slot is marked complete.
- R6: Among ready entries, the one nearest the head (in circular order) is issued; `exec_tag` gives its slot index.
- R7: A completed trapping instruction at the head raises `flush_out` for one cycle. It writes no register, empties the queue and clears all rename mappings.
- R8: Every renamed register names an occupied slot whose destination is that register.
- R9: Retirement releases a register's rename mapping only if the mapping still names the retiring slot, so a younger writer of the same register keeps its mapping.
- R10: Opcode encoding on `disp_op`: 0 adds, 1 subtracts (src1 minus src2), 2 is bitwise XOR, 3 traps (result src1, no register write, flush at the head). All arithmetic is modulo 2^DATA_W.
- R11: While `alu_free` is 0 no entry executes and no entry becomes complete.
- R12: Only an occupied, not yet executed entry is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Instruction offered for dispatch |
| disp_op | input | 2 | Opcode (R10) |
| disp_dest | input | REG_W | Destination register |
| disp_src1 | input | REG_W | First source register |
| disp_src2 | input | REG_W | Second source register |
| disp_ready | output | 1 | Dispatch accepted at the next edge when disp_valid is 1 |
| alu_free | input | 1 | ALU may take an instruction this cycle |
| exec_valid | output | 1 | An entry issues this cycle |
| exec_tag | output | TAG_W | Slot index of the issuing entry |
| ret_valid | output | 1 | Head entry retires this cycle |
| ret_dest | output | REG_W | Destination of the retiring entry |
| ret_value | output | DATA_W | Value written by the retiring entry |
| flush_out | output | 1 | Trap at head; queue is discarded this cycle |
| rf_rd_addr | input | REG_W | Architectural register read address |
| rf_rd_data | output | DATA_W | Architectural register contents |

## Verification
The bench keeps its own sequential model of the register file and compares every retirement and every flush against it. It uses eight registers so that most instructions depend on recent ones. A source read in the same cycle its producer executes or retires is a likely bug: a design that misses this forward leaves the entry waiting forever or latches a stale register value, and the retirement compare then fails. A chain of two writes to one register followed by a reader catches a design that releases a mapping unconditionally: the reader then takes the older value. With the ALU held back, the bench fills the queue. This shows whether dispatch stalls at full and whether the oldest entry wins the pick. Random traps check that everything younger is dropped and the model's register file stays in step.

// File: rtl/ooo_rob_pkg.sv
package ooo_rob_pkg;
    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_XOR  = 2'd2,
        OP_TRAP = 2'd3
    } op_t;
endpackage

// File: rtl/rob_pick.sv
module rob_pick #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input  logic [DEPTH-1:0] ready,
    input  logic [TAG_W-1:0] head,
    output logic             found,
    output logic [TAG_W-1:0] idx
);
    // Scan circularly from head; first ready slot is the oldest.
    always_comb begin
        logic [TAG_W-1:0] cand;
        found = 1'b0;
        idx   = head;
        for (int k = 0; k < DEPTH; k++) begin
            cand = head + TAG_W'(k);
            if (!found && ready[cand]) begin
                found = 1'b1;
                idx   = cand;
            end
        end
    end
endmodule

// File: rtl/rob_alu.sv
module rob_alu
    import ooo_rob_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  op_t              op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output logic              exc
);
    always_comb begin
        exc = 1'b0;
        unique case (op)
            OP_ADD:  result = a + b;
            OP_SUB:  result = a - b;
            OP_XOR:  result = a ^ b;
            default: begin
                result = a;
                exc    = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ooo_rob_core.sv
module ooo_rob_core
    import ooo_rob_pkg::*;
#(
    parameter int DEPTH  = 4,   // power of two
    parameter int NREGS  = 8,
    parameter int DATA_W = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREGS),
    localparam int PTR_W = TAG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [1:0]        disp_op,
    input  logic [REG_W-1:0]  disp_dest,
    input  logic [REG_W-1:0]  disp_src1,
    input  logic [REG_W-1:0]  disp_src2,
    output logic              disp_ready,
    input  logic              alu_free,
    output logic              exec_valid,
    output logic [TAG_W-1:0]  exec_tag,
    output logic              ret_valid,
    output logic [REG_W-1:0]  ret_dest,
    output logic [DATA_W-1:0] ret_value,
    output logic              flush_out,
    input  logic [REG_W-1:0]  rf_rd_addr,
    output logic [DATA_W-1:0] rf_rd_data
);
    typedef struct packed {
        logic              rdy;
        logic [DATA_W-1:0] val;
        logic [TAG_W-1:0]  tag;
    } operand_t;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              exc;
        op_t               op;
        logic [REG_W-1:0]  dest;
        operand_t          s1;
        operand_t          s2;
        logic [DATA_W-1:0] result;
    } entry_t;

    typedef struct packed {
        logic              busy;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } ren_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        ren_t   [NREGS-1:0] ren;
        logic   [PTR_W-1:0] head;
        logic   [PTR_W-1:0] tail;
    } state_t;

    state_t state_q, state_d;

    logic [TAG_W-1:0]  head_idx, tail_idx, pick_idx;
    logic [PTR_W-1:0]  occupancy;
    logic [DEPTH-1:0]  ready_vec;
    logic              pick_found, issue, head_done, flush_now, commit_now, full, disp_take;
    logic [DATA_W-1:0] alu_res;
    logic              alu_exc;

    assign head_idx  = state_q.head[TAG_W-1:0];
    assign tail_idx  = state_q.tail[TAG_W-1:0];
    assign occupancy = state_q.tail - state_q.head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ready
        assign ready_vec[i] = state_q.ent[i].valid && !state_q.ent[i].done
                              && state_q.ent[i].s1.rdy && state_q.ent[i].s2.rdy;
    end

    rob_pick #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_pick (
        .ready (ready_vec),
        .head  (head_idx),
        .found (pick_found),
        .idx   (pick_idx)
    );

    rob_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (state_q.ent[pick_idx].op),
        .a      (state_q.ent[pick_idx].s1.val),
        .b      (state_q.ent[pick_idx].s2.val),
        .result (alu_res),
        .exc    (alu_exc)
    );

    assign head_done  = state_q.ent[head_idx].valid && state_q.ent[head_idx].done;
    assign flush_now  = head_done && state_q.ent[head_idx].exc;
    assign commit_now = head_done && !state_q.ent[head_idx].exc;
    assign issue      = pick_found && alu_free && !flush_now;
    assign full       = (occupancy == PTR_W'(DEPTH));
    assign disp_ready = !full && !flush_now;
    assign disp_take  = disp_valid && disp_ready;

    // Source lookup against the current state, with same-cycle ALU forwarding.
    function automatic operand_t resolve(input state_t s, input logic [REG_W-1:0] r,
                                         input logic fwd, input logic [TAG_W-1:0] fwd_tag,
                                         input logic [DATA_W-1:0] fwd_val);
        operand_t o;
        o.rdy = 1'b1;
        o.tag = s.ren[r].tag;
        o.val = s.ren[r].value;
        if (s.ren[r].busy) begin
            if (s.ent[o.tag].done)
                o.val = s.ent[o.tag].result;
            else if (fwd && fwd_tag == o.tag)
                o.val = fwd_val;
            else begin
                o.rdy = 1'b0;
                o.val = '0;
            end
        end
        return o;
    endfunction

    always_comb begin
        state_d = state_q;
        if (flush_now) begin
            for (int i = 0; i < DEPTH; i++) state_d.ent[i].valid = 1'b0;
            for (int r = 0; r < NREGS; r++) state_d.ren[r].busy = 1'b0;
            state_d.head = state_q.tail;
        end else begin
            if (issue) begin
                state_d.ent[pick_idx].done   = 1'b1;
                state_d.ent[pick_idx].result = alu_res;
                state_d.ent[pick_idx].exc    = alu_exc;
                for (int i = 0; i < DEPTH; i++) begin
                    if (state_q.ent[i].valid && !state_q.ent[i].s1.rdy
                        && state_q.ent[i].s1.tag == pick_idx) begin
                        state_d.ent[i].s1.rdy = 1'b1;
                        state_d.ent[i].s1.val = alu_res;
                    end
                    if (state_q.ent[i].valid && !state_q.ent[i].s2.rdy
                        && state_q.ent[i].s2.tag == pick_idx) begin
                        state_d.ent[i].s2.rdy = 1'b1;
                        state_d.ent[i].s2.val = alu_res;
                    end
                end
            end
            if (commit_now) begin
                state_d.ent[head_idx].valid = 1'b0;
                state_d.ren[state_q.ent[head_idx].dest].value = state_q.ent[head_idx].result;
                if (state_q.ren[state_q.ent[head_idx].dest].busy
                    && state_q.ren[state_q.ent[head_idx].dest].tag == head_idx)
                    state_d.ren[state_q.ent[head_idx].dest].busy = 1'b0;
                state_d.head = state_q.head + 1'b1;
            end
            if (disp_take) begin
                state_d.ent[tail_idx].valid = 1'b1;
                state_d.ent[tail_idx].done  = 1'b0;
                state_d.ent[tail_idx].exc   = 1'b0;
                state_d.ent[tail_idx].op    = op_t'(disp_op);
                state_d.ent[tail_idx].dest  = disp_dest;
                state_d.ent[tail_idx].s1    = resolve(state_q, disp_src1, issue, pick_idx, alu_res);
                state_d.ent[tail_idx].s2    = resolve(state_q, disp_src2, issue, pick_idx, alu_res);
                state_d.ent[tail_idx].result = '0;
                state_d.ren[disp_dest].busy = 1'b1;
                state_d.ren[disp_dest].tag  = tail_idx;
                state_d.tail = state_q.tail + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            for (int r = 0; r < NREGS; r++) state_q.ren[r].value <= DATA_W'(r);
        end else begin
            state_q <= state_d;
        end
    end

    assign exec_valid = issue;
    assign exec_tag   = pick_idx;
    assign ret_valid  = commit_now;
    assign ret_dest   = state_q.ent[head_idx].dest;
    assign ret_value  = state_q.ent[head_idx].result;
    assign flush_out  = flush_now;
    assign rf_rd_data = state_q.ren[rf_rd_addr].value;

    // Flattened views of the state for the bound checker.
    logic [DEPTH-1:0]       occ_vec, done_vec;
    logic [NREGS-1:0]       ren_busy_vec;
    logic [NREGS*TAG_W-1:0] ren_tag_flat;
    logic [DEPTH*REG_W-1:0] dest_flat;
    for (genvar i = 0; i < DEPTH; i++) begin : g_flat_ent
        assign occ_vec[i]                  = state_q.ent[i].valid;
        assign done_vec[i]                 = state_q.ent[i].valid && state_q.ent[i].done;
        assign dest_flat[i*REG_W +: REG_W] = state_q.ent[i].dest;
    end
    for (genvar r = 0; r < NREGS; r++) begin : g_flat_ren
        assign ren_busy_vec[r]                = state_q.ren[r].busy;
        assign ren_tag_flat[r*TAG_W +: TAG_W] = state_q.ren[r].tag;
    end
endmodule

// File: rtl/ooo_rob_core_chk.sv
module ooo_rob_core_chk #(
    parameter int DEPTH = 4,
    parameter int NREGS = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREGS),
    localparam int PTR_W = TAG_W + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   alu_free,
    input logic                   exec_valid,
    input logic [TAG_W-1:0]       exec_tag,
    input logic                   ret_valid,
    input logic                   flush_out,
    input logic [PTR_W-1:0]       head_q,
    input logic [PTR_W-1:0]       tail_q,
    input logic [DEPTH-1:0]       occ_vec,
    input logic [DEPTH-1:0]       done_vec,
    input logic [NREGS-1:0]       ren_busy_vec,
    input logic [NREGS*TAG_W-1:0] ren_tag_flat,
    input logic [DEPTH*REG_W-1:0] dest_flat
);
    logic [PTR_W-1:0] fill;
    assign fill = tail_q - head_q;

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= PTR_W'(DEPTH));

    assert_head_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> head_q == PTR_W'($past(head_q) + 1'b1));

    assert_issue_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> done_vec[$past(exec_tag)]);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_out |=> occ_vec == '0);

    assert_stall_no_complete_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_free |=> (done_vec & ~$past(done_vec)) == '0);

    assert_issue_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> occ_vec[exec_tag] && !done_vec[exec_tag]);

    for (genvar r = 0; r < NREGS; r++) begin : g_ren
        assert_rename_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ren_busy_vec[r] |->
                occ_vec[ren_tag_flat[r*TAG_W +: TAG_W]]
                && dest_flat[ren_tag_flat[r*TAG_W +: TAG_W]*REG_W +: REG_W] == REG_W'(r));
    end
endmodule

bind ooo_rob_core ooo_rob_core_chk #(.DEPTH(DEPTH), .NREGS(NREGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alu_free     (alu_free),
    .exec_valid   (exec_valid),
    .exec_tag     (exec_tag),
    .ret_valid    (ret_valid),
    .flush_out    (flush_out),
    .head_q       (state_q.head),
    .tail_q       (state_q.tail),
    .occ_vec      (occ_vec),
    .done_vec     (done_vec),
    .ren_busy_vec (ren_busy_vec),
    .ren_tag_flat (ren_tag_flat),
    .dest_flat    (dest_flat)
);

// File: tb/tb_ooo_rob_core.sv
`timescale 1ns/1ps
module tb_ooo_rob_core;
    localparam int DEPTH = 4;
    localparam int NREGS = 8;
    localparam int QMAX  = 4096;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_valid = 1'b0;
    logic [1:0] disp_op = '0;
    logic [2:0] disp_dest = '0, disp_src1 = '0, disp_src2 = '0;
    logic       disp_ready;
    logic       alu_free = 1'b0;
    logic       exec_valid;
    logic [1:0] exec_tag;
    logic       ret_valid;
    logic [2:0] ret_dest;
    logic [7:0] ret_value;
    logic       flush_out;
    logic [2:0] rf_rd_addr = '0;
    logic [7:0] rf_rd_data;

    always #10 clk = ~clk;

    ooo_rob_core #(.DEPTH(DEPTH), .NREGS(NREGS), .DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_op(disp_op), .disp_dest(disp_dest),
        .disp_src1(disp_src1), .disp_src2(disp_src2), .disp_ready(disp_ready),
        .alu_free(alu_free), .exec_valid(exec_valid), .exec_tag(exec_tag),
        .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_value(ret_value),
        .flush_out(flush_out), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data)
    );

    int total = 0, failn = 0, flushes = 0, tail_b = 0;
    bit finished = 1'b0;
    logic [7:0] spec_rf [NREGS];
    logic [7:0] comm_rf [NREGS];
    logic [2:0] q_dest [QMAX];
    logic [7:0] q_val  [QMAX];
    bit         q_exc  [QMAX];
    int qh = 0, qt = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failn++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_alu(input int op, input logic [7:0] a, input logic [7:0] b);
        case (op)
            0:       return a + b;   // R10 add
            1:       return a - b;   // R10 sub
            2:       return a ^ b;   // R10 xor
            default: return a;       // R10 trap
        endcase
    endfunction

    // Compare retirement/flush activity of the current cycle with the model.
    task automatic observe();
        if (flush_out) begin
            chk(qh != qt && q_exc[qh % QMAX], "R7 flush only on trap at head", 1, 0);
            chk(!ret_valid, "R7 no write during flush", ret_valid, 0);
            qh = qt;
            for (int r = 0; r < NREGS; r++) spec_rf[r] = comm_rf[r];
            flushes++;
        end else if (ret_valid) begin
            if (qh == qt) begin
                chk(1'b0, "R3 retire with nothing pending", 1, 0);
            end else begin
                chk(!q_exc[qh % QMAX], "R7 trap retired as normal", 1, 0);
                chk(ret_dest == q_dest[qh % QMAX], "R3 retire dest", ret_dest, q_dest[qh % QMAX]);
                chk(ret_value == q_val[qh % QMAX], "R4 retire value", ret_value, q_val[qh % QMAX]);
                comm_rf[ret_dest] = ret_value;
                qh++;
            end
        end
    endtask

    task automatic idle(input bit free);
        @(negedge clk);
        observe();
        disp_valid = 1'b0;
        alu_free   = free;
    endtask

    // Offer one instruction until accepted; record it in the model.
    task automatic send(input int op, input int d, input int a, input int b,
                        input bit free, input bit rnd_free);
        bit sent = 1'b0;
        while (!sent) begin
            @(negedge clk);
            observe();
            alu_free = rnd_free ? (($urandom % 4) != 0) : free;
            if (disp_ready) begin
                disp_valid = 1'b1;
                disp_op    = 2'(op);
                disp_dest  = 3'(d);
                disp_src1  = 3'(a);
                disp_src2  = 3'(b);
                q_dest[qt % QMAX] = 3'(d);
                q_val[qt % QMAX]  = ref_alu(op, spec_rf[a], spec_rf[b]);
                q_exc[qt % QMAX]  = (op == 3);
                if (op != 3) spec_rf[d] = q_val[qt % QMAX];
                qt++;
                tail_b++;
                sent = 1'b1;
            end else begin
                disp_valid = 1'b0;
            end
        end
    endtask

    task automatic drain(input string req);
        for (int c = 0; c < 30; c++) idle(1'b1);
        chk(qh == qt, req, qt - qh, 0);
    endtask

    task automatic compare_rf(input string req);
        for (int r = 0; r < NREGS; r++) begin
            rf_rd_addr = 3'(r);
            #1;
            chk(rf_rd_data == comm_rf[r], req, rf_rd_data, comm_rf[r]);
        end
    endtask

    initial begin
        for (int r = 0; r < NREGS; r++) begin
            spec_rf[r] = 8'(r);
            comm_rf[r] = 8'(r);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(disp_ready, "R1 ready after reset", disp_ready, 1);
        chk(!ret_valid, "R1 no retire after reset", ret_valid, 0);
        chk(!exec_valid, "R1 no issue after reset", exec_valid, 0);
        chk(!flush_out, "R1 no flush after reset", flush_out, 0);
        compare_rf("R1 register reset value");

        // R9 / R5: two writers of r1, then a reader while both pending
        send(0, 1, 2, 3, 1'b0, 1'b0);
        send(1, 1, 4, 5, 1'b0, 1'b0);
        send(2, 7, 1, 6, 1'b0, 1'b0);
        idle(1'b0);
        chk(!exec_valid, "R11 no issue while ALU busy", exec_valid, 0);
        drain("R9 all retired");
        compare_rf("R9 younger writer mapping kept");

        // R2 / R6: fill the queue with independent work, ALU held
        for (int k = 0; k < DEPTH; k++) begin
            send(0, k, 4 + k, 4, 1'b0, 1'b0);
        end
        idle(1'b0);
        chk(!disp_ready, "R2 stall when full", disp_ready, 0);
        chk(!exec_valid, "R11 no issue while ALU busy", exec_valid, 0);
        alu_free = 1'b1;
        #1;
        chk(exec_valid, "R6 issue once ALU free", exec_valid, 1);
        chk(exec_tag == 2'(tail_b % DEPTH), "R6 oldest entry picked", exec_tag, tail_b % DEPTH);
        drain("R2 full queue drains");
        compare_rf("R3 register file after fill");

        // Dense random stream: dependencies, stalls and traps
        for (int n = 0; n < 1500; n++) begin
            if (($urandom % 6) == 0) begin
                idle(($urandom % 4) != 0);
            end else begin
                int op;
                op = (($urandom % 16) == 0) ? 3 : int'($urandom % 3);
                send(op, $urandom % NREGS, $urandom % NREGS, $urandom % NREGS, 1'b1, 1'b1);
            end
        end
        drain("R3 random stream retired");
        compare_rf("R4 register file matches sequential model");
        chk(flushes > 0, "R7 traps exercised", flushes, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - failn, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            failn++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", total - failn, total);
            $finish;
        end
    end
endmodule